// File: doc/BRIEF.md
# SPI Message Transfer Sequencer

This block runs queued SPI messages through a byte-level serial engine. A message is taken in through a descriptor handshake that also carries its clock polarity, clock phase, bit order and divider. These settings go to the engine once, before the message's first byte. The message is then made of one or more transfer descriptors. Each transfer descriptor gives a byte count, a post-transfer delay in microseconds, a flag that allows chip select to drop after that transfer, a flag that says whether transmit bytes come from the transmit stream, and a flag that marks the last transfer of the message.

For every byte, the sequencer writes the engine and waits for a completion event. It answers each event with a status/data read strobe. It then pushes a good received byte to the receive stream, resends the same byte after a write collision, or aborts the message after a mode fault. After the last byte of a transfer, a timer holds the sequencer for the requested delay. The transfer's length is then added to the message's length counter, and the sequencer moves on to the next transfer or finishes the message with a done pulse and an error flag.

Top module: `spiseq_top`

## Requirements
- R1: After reset, csN is high, msgDone and msgError are low, engWrite is low, and msgReady is high.
- R2: When a message is accepted (msgValid and msgReady in the same cycle), engCfgWe is high in that cycle and only then, carrying the message's polarity, phase, bit order and divider on engCpol, engCpha, engLsbFirst and engDivider.
- R3: csN is low in every cycle in which engWrite is high, and csN is high in the cycle in which msgDone is high.
- R4: Between two transfers of one message, csN goes high for at least one cycle only if the earlier transfer's xferCsChange is 1. A message therefore shows 1 + (number of non-last transfers with xferCsChange=1) rising edges of csN.
- R5: When xferHasTx is 1, each new byte write carries the txData accepted in that cycle (txReady and txValid both high). When xferHasTx is 0, txReady stays low and every new byte write carries 0.
- R6: Each completion event (evtValid high while a byte is in flight) is followed in the next cycle by a single-cycle engRead, and engRead never coincides with engWrite.
- R7: An event with evtWcol=1 causes, two cycles after the event, a write of the same byte as the previous write. It produces no rxValid and does not count toward the transfer length.
- R8: An event with evtModf=1 (and evtWcol=0) causes csN high, msgDone high and msgError high two cycles after the event. The message ends, and msgActualLen holds only the lengths of transfers that completed.
- R9: After a transfer's last good byte, the sequencer waits xferDelayUs*TICKS_PER_US cycles. For the last transfer, msgDone rises exactly xferDelayUs*TICKS_PER_US+2 cycles after the cycle with the last rxValid.
- R10: On a successful msgDone, msgError is 0 and msgActualLen equals the sum of the message's transfer lengths.
- R11: Each good completion event produces exactly one rxValid, in the same cycle as its engRead, with rxData equal to the event's evtData.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| msgValid | input | 1 | Message descriptor offered |
| msgReady | output | 1 | Sequencer idle, takes a message |
| msgCpol | input | 1 | Message clock polarity |
| msgCpha | input | 1 | Message clock phase |
| msgLsbFirst | input | 1 | Message bit order, 1 = LSB first |
| msgDivider | input | DIV_W | Message clock divider code |
| xferValid | input | 1 | Transfer descriptor offered |
| xferReady | output | 1 | Sequencer takes a transfer descriptor |
| xferLen | input | LEN_W | Bytes in the transfer, at least 1 |
| xferDelayUs | input | DLY_W | Post-transfer delay in microseconds |
| xferCsChange | input | 1 | Drop chip select after this transfer |
| xferHasTx | input | 1 | Transmit bytes come from the tx stream |
| xferLast | input | 1 | Last transfer of the message |
| txValid | input | 1 | Transmit byte available |
| txReady | output | 1 | Transmit byte consumed |
| txData | input | DATA_W | Transmit byte |
| rxValid | output | 1 | Received byte pulse |
| rxData | output | DATA_W | Received byte |
| engCfgWe | output | 1 | Engine configuration write strobe |
| engCpol | output | 1 | Polarity for the engine |
| engCpha | output | 1 | Phase for the engine |
| engLsbFirst | output | 1 | Bit order for the engine |
| engDivider | output | DIV_W | Divider for the engine |
| engWrite | output | 1 | Byte write strobe to the engine |
| engWrData | output | DATA_W | Byte written to the engine |
| engRead | output | 1 | Status/data read strobe |
| evtValid | input | 1 | Engine completion event |
| evtWcol | input | 1 | Event is a write collision |
| evtModf | input | 1 | Event is a mode fault |
| evtData | input | DATA_W | Byte received by the engine |
| csN | output | 1 | Chip select, active low |
| msgDone | output | 1 | Message finished pulse |
| msgError | output | 1 | Message ended by a fault |
| msgActualLen | output | ACT_W | Bytes of completed transfers |

## Verification
Messages are run from a table that mixes single and two-transfer messages, streamed and zero-filled bytes, and transfer boundaries with and without the chip-select change flag. These patterns separate the rule that keeps select asserted between transfers from the rule that drops it. Collisions are injected on the first byte of a later transfer and in mid-transfer. Their byte and length counts would differ from a clean run if the retry advanced the count or pushed a byte. Mode faults are injected on the first byte of a message and on the first byte of its second transfer, which shows whether the length counter keeps exactly the completed transfers. A directed run with a nonzero delay measures the distance from the last received byte to the done pulse.

// File: rtl/spiseq_pkg.sv
package spiseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SEND,
    ST_BUSY,
    ST_ACK,
    ST_RETRY,
    ST_WAIT
  } seqState_t;

  typedef struct packed {
    logic loadMsg;
    logic loadXfer;
    logic sendNew;
    logic sendRetry;
    logic captureEvt;
    logic evtRead;
    logic rxPush;
    logic loadTimer;
    logic decTimer;
    logic addLen;
    logic csOff;
    logic finishOk;
    logic finishErr;
  } seqStrobe_t;

endpackage

// File: rtl/spiseq_ctrl.sv
module spiseq_ctrl
  import spiseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       msgValid,
  input  logic       xferValid,
  input  logic       txValid,
  input  logic       evtValid,
  input  logic       remIsOne,
  input  logic       timerZero,
  input  logic       evtWcolQ,
  input  logic       evtModfQ,
  input  logic       xferHasTxQ,
  input  logic       xferLastQ,
  input  logic       xferCsChgQ,
  output logic       msgReady,
  output logic       xferReady,
  output logic       txReady,
  output logic       engCfgWe,
  output seqStrobe_t strb
);

  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    msgReady  = 1'b0;
    xferReady = 1'b0;
    txReady   = 1'b0;
    engCfgWe  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        msgReady = 1'b1;
        if (msgValid) begin
          engCfgWe     = 1'b1;
          strb.loadMsg = 1'b1;
          nextState    = ST_FETCH;
        end
      end
      ST_FETCH: begin
        xferReady = 1'b1;
        if (xferValid) begin
          strb.loadXfer = 1'b1;
          nextState     = ST_SEND;
        end
      end
      ST_SEND: begin
        if (xferHasTxQ) begin
          txReady = 1'b1;
          if (txValid) begin
            strb.sendNew = 1'b1;
            nextState    = ST_BUSY;
          end
        end else begin
          strb.sendNew = 1'b1;
          nextState    = ST_BUSY;
        end
      end
      ST_BUSY: begin
        if (evtValid) begin
          strb.captureEvt = 1'b1;
          nextState       = ST_ACK;
        end
      end
      ST_ACK: begin
        strb.evtRead = 1'b1;
        if (evtWcolQ) begin
          nextState = ST_RETRY;
        end else if (evtModfQ) begin
          strb.csOff     = 1'b1;
          strb.finishErr = 1'b1;
          nextState      = ST_IDLE;
        end else begin
          strb.rxPush = 1'b1;
          if (remIsOne) begin
            strb.loadTimer = 1'b1;
            nextState      = ST_WAIT;
          end else begin
            nextState = ST_SEND;
          end
        end
      end
      ST_RETRY: begin
        strb.sendRetry = 1'b1;
        nextState      = ST_BUSY;
      end
      ST_WAIT: begin
        if (!timerZero) begin
          strb.decTimer = 1'b1;
        end else begin
          strb.addLen = 1'b1;
          if (xferLastQ) begin
            strb.csOff    = 1'b1;
            strb.finishOk = 1'b1;
            nextState     = ST_IDLE;
          end else begin
            strb.csOff = xferCsChgQ;
            nextState  = ST_FETCH;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/spiseq_datapath.sv
module spiseq_datapath
  import spiseq_pkg::*;
#(
  parameter int LEN_W        = 8,
  parameter int DLY_W        = 8,
  parameter int DATA_W       = 8,
  parameter int TICKS_PER_US = 4,
  parameter int ACT_W        = LEN_W + 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [LEN_W-1:0]  xferLen,
  input  logic [DLY_W-1:0]  xferDelayUs,
  input  logic              xferCsChange,
  input  logic              xferHasTx,
  input  logic              xferLast,
  input  logic [DATA_W-1:0] txData,
  input  logic              evtWcol,
  input  logic              evtModf,
  input  logic [DATA_W-1:0] evtData,
  output logic              remIsOne,
  output logic              timerZero,
  output logic              evtWcolQ,
  output logic              evtModfQ,
  output logic              xferHasTxQ,
  output logic              xferLastQ,
  output logic              xferCsChgQ,
  output logic              engWrite,
  output logic [DATA_W-1:0] engWrData,
  output logic              engRead,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxData,
  output logic              csN,
  output logic              msgDone,
  output logic              msgError,
  output logic [ACT_W-1:0]  msgActualLen
);

  localparam int TMR_W = DLY_W + $clog2(TICKS_PER_US + 1);

  logic [LEN_W-1:0]  remCnt;
  logic [LEN_W-1:0]  lenQ;
  logic [DLY_W-1:0]  delayQ;
  logic [TMR_W-1:0]  timer;
  logic [DATA_W-1:0] lastTx;
  logic [DATA_W-1:0] evtDataQ;
  logic [DATA_W-1:0] newByte;

  assign newByte   = xferHasTxQ ? txData : '0;
  assign engWrite  = strb.sendNew | strb.sendRetry;
  assign engWrData = strb.sendRetry ? lastTx : newByte;
  assign engRead   = strb.evtRead;
  assign rxValid   = strb.rxPush;
  assign rxData    = evtDataQ;
  assign remIsOne  = (remCnt == LEN_W'(1));
  assign timerZero = (timer == '0);

  // Transfer descriptor and byte counting
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remCnt     <= '0;
      lenQ       <= '0;
      delayQ     <= '0;
      xferHasTxQ <= 1'b0;
      xferLastQ  <= 1'b0;
      xferCsChgQ <= 1'b0;
    end else if (strb.loadXfer) begin
      remCnt     <= xferLen;
      lenQ       <= xferLen;
      delayQ     <= xferDelayUs;
      xferHasTxQ <= xferHasTx;
      xferLastQ  <= xferLast;
      xferCsChgQ <= xferCsChange;
    end else if (strb.rxPush) begin
      remCnt <= remCnt - LEN_W'(1);
    end
  end

  // Last written byte and captured engine event
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastTx   <= '0;
      evtDataQ <= '0;
      evtWcolQ <= 1'b0;
      evtModfQ <= 1'b0;
    end else begin
      if (strb.sendNew) lastTx <= newByte;
      if (strb.captureEvt) begin
        evtDataQ <= evtData;
        evtWcolQ <= evtWcol;
        evtModfQ <= evtModf;
      end
    end
  end

  // Post-transfer delay timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer <= '0;
    end else if (strb.loadTimer) begin
      timer <= TMR_W'(delayQ) * TMR_W'(TICKS_PER_US);
    end else if (strb.decTimer) begin
      timer <= timer - TMR_W'(1);
    end
  end

  // Chip select, message length and completion
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csN          <= 1'b1;
      msgDone      <= 1'b0;
      msgError     <= 1'b0;
      msgActualLen <= '0;
    end else begin
      if (strb.loadXfer)   csN <= 1'b0;
      else if (strb.csOff) csN <= 1'b1;
      if (strb.loadMsg)     msgActualLen <= '0;
      else if (strb.addLen) msgActualLen <= msgActualLen + ACT_W'(lenQ);
      msgDone  <= strb.finishOk | strb.finishErr;
      msgError <= strb.finishErr;
    end
  end

endmodule

// File: rtl/spiseq_top.sv
module spiseq_top
  import spiseq_pkg::*;
#(
  parameter int LEN_W        = 8,
  parameter int DLY_W        = 8,
  parameter int DATA_W       = 8,
  parameter int DIV_W        = 3,
  parameter int TICKS_PER_US = 4,
  localparam int ACT_W       = LEN_W + 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              msgValid,
  output logic              msgReady,
  input  logic              msgCpol,
  input  logic              msgCpha,
  input  logic              msgLsbFirst,
  input  logic [DIV_W-1:0]  msgDivider,
  input  logic              xferValid,
  output logic              xferReady,
  input  logic [LEN_W-1:0]  xferLen,
  input  logic [DLY_W-1:0]  xferDelayUs,
  input  logic              xferCsChange,
  input  logic              xferHasTx,
  input  logic              xferLast,
  input  logic              txValid,
  output logic              txReady,
  input  logic [DATA_W-1:0] txData,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxData,
  output logic              engCfgWe,
  output logic              engCpol,
  output logic              engCpha,
  output logic              engLsbFirst,
  output logic [DIV_W-1:0]  engDivider,
  output logic              engWrite,
  output logic [DATA_W-1:0] engWrData,
  output logic              engRead,
  input  logic              evtValid,
  input  logic              evtWcol,
  input  logic              evtModf,
  input  logic [DATA_W-1:0] evtData,
  output logic              csN,
  output logic              msgDone,
  output logic              msgError,
  output logic [ACT_W-1:0]  msgActualLen
);

  seqStrobe_t strb;
  logic remIsOne, timerZero, evtWcolQ, evtModfQ;
  logic xferHasTxQ, xferLastQ, xferCsChgQ;

  assign engCpol     = msgCpol;
  assign engCpha     = msgCpha;
  assign engLsbFirst = msgLsbFirst;
  assign engDivider  = msgDivider;

  spiseq_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .msgValid   (msgValid),
    .xferValid  (xferValid),
    .txValid    (txValid),
    .evtValid   (evtValid),
    .remIsOne   (remIsOne),
    .timerZero  (timerZero),
    .evtWcolQ   (evtWcolQ),
    .evtModfQ   (evtModfQ),
    .xferHasTxQ (xferHasTxQ),
    .xferLastQ  (xferLastQ),
    .xferCsChgQ (xferCsChgQ),
    .msgReady   (msgReady),
    .xferReady  (xferReady),
    .txReady    (txReady),
    .engCfgWe   (engCfgWe),
    .strb       (strb)
  );

  spiseq_datapath #(
    .LEN_W        (LEN_W),
    .DLY_W        (DLY_W),
    .DATA_W       (DATA_W),
    .TICKS_PER_US (TICKS_PER_US),
    .ACT_W        (ACT_W)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .xferLen      (xferLen),
    .xferDelayUs  (xferDelayUs),
    .xferCsChange (xferCsChange),
    .xferHasTx    (xferHasTx),
    .xferLast     (xferLast),
    .txData       (txData),
    .evtWcol      (evtWcol),
    .evtModf      (evtModf),
    .evtData      (evtData),
    .remIsOne     (remIsOne),
    .timerZero    (timerZero),
    .evtWcolQ     (evtWcolQ),
    .evtModfQ     (evtModfQ),
    .xferHasTxQ   (xferHasTxQ),
    .xferLastQ    (xferLastQ),
    .xferCsChgQ   (xferCsChgQ),
    .engWrite     (engWrite),
    .engWrData    (engWrData),
    .engRead      (engRead),
    .rxValid      (rxValid),
    .rxData       (rxData),
    .csN          (csN),
    .msgDone      (msgDone),
    .msgError     (msgError),
    .msgActualLen (msgActualLen)
  );

endmodule

// File: rtl/spiseq_chk.sv
module spiseq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              engWrite,
  input logic [DATA_W-1:0] engWrData,
  input logic              engRead,
  input logic              evtValid,
  input logic              evtWcol,
  input logic              evtModf,
  input logic              rxValid,
  input logic              csN,
  input logic              msgDone,
  input logic              msgError
);

  logic [DATA_W-1:0] prevWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         prevWr <= '0;
    else if (engWrite) prevWr <= engWrData;
  end

  // R3
  cs_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    engWrite |-> !csN);

  // R3
  cs_off_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgDone |-> csN);

  // R6
  read_after_evt_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |=> engRead);

  // R6
  read_not_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    engRead |-> !engWrite);

  // R7
  wcol_retry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtWcol) |=> ##1 (engWrite && engWrData == prevWr));

  // R8
  modf_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtModf && !evtWcol) |=> ##1 (csN && msgDone && msgError));

  // R8
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgError |-> msgDone);

  // R11
  rx_with_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> engRead);

endmodule

bind spiseq_top spiseq_chk #(.DATA_W(DATA_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .engWrite  (engWrite),
  .engWrData (engWrData),
  .engRead   (engRead),
  .evtValid  (evtValid),
  .evtWcol   (evtWcol),
  .evtModf   (evtModf),
  .rxValid   (rxValid),
  .csN       (csN),
  .msgDone   (msgDone),
  .msgError  (msgError)
);

// File: tb/tb_spiseq_top.sv
module tb_spiseq_top;

  localparam int CLK_PERIOD = 10;
  localparam int TICKS      = 4;

  typedef struct packed {
    int nx; int len0; int len1; int dly0; int dly1; int cs0; int tx0; int tx1;
    int wcolAt; int modfAt; int expLen; int expErr; int expRx; int expDeas;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1, 3, 1, 0, 0, 0, 1, 0, 0, 0, 3, 0, 3, 1},
    '{1, 2, 1, 1, 0, 0, 0, 0, 0, 0, 2, 0, 2, 1},
    '{2, 2, 3, 1, 0, 1, 1, 0, 0, 0, 5, 0, 5, 2},
    '{2, 1, 2, 2, 1, 0, 1, 1, 0, 0, 3, 0, 3, 1},
    '{1, 3, 1, 0, 0, 0, 1, 0, 2, 0, 3, 0, 3, 1},
    '{2, 2, 2, 0, 0, 0, 1, 1, 0, 3, 2, 1, 2, 1},
    '{1, 4, 1, 0, 0, 0, 1, 0, 0, 1, 0, 1, 0, 1},
    '{2, 1, 1, 0, 0, 1, 0, 1, 2, 0, 2, 0, 2, 2}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        msgValid = 1'b0, msgReady;
  logic        msgCpol = 1'b0, msgCpha = 1'b0, msgLsbFirst = 1'b0;
  logic [2:0]  msgDivider = '0;
  logic        xferValid = 1'b0, xferReady;
  logic [7:0]  xferLen = '0, xferDelayUs = '0;
  logic        xferCsChange = 1'b0, xferHasTx = 1'b0, xferLast = 1'b0;
  logic        txValid = 1'b1, txReady;
  logic [7:0]  txData = 8'h11;
  logic        rxValid;
  logic [7:0]  rxData;
  logic        engCfgWe, engCpol, engCpha, engLsbFirst;
  logic [2:0]  engDivider;
  logic        engWrite, engRead;
  logic [7:0]  engWrData;
  logic        evtValid = 1'b0, evtWcol = 1'b0, evtModf = 1'b0;
  logic [7:0]  evtData = '0;
  logic        csN, msgDone, msgError;
  logic [11:0] msgActualLen;

  spiseq_top #(.TICKS_PER_US(TICKS)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // engine model and monitors
  int wrNum = 0, rxCnt = 0, deas = 0, cfgCnt = 0, lastRxCyc = 0;
  int wcolAt = 0, modfAt = 0, pendCnt = 0;
  bit curHasTx = 0, retryExp = 0, advTx = 0, pW = 0, pM = 0, expRead = 0, prevCsN = 1;
  logic [7:0] lastWr = '0;

  initial begin
    forever begin
      @(negedge clk);
      if (advTx) begin txData = txData + 8'h1D; advTx = 0; end
      if (expRead) check(engRead === 1'b1, "R6", int'(engRead), 1);
      evtValid = 0; evtWcol = 0; evtModf = 0;
      if (pendCnt == 1) begin
        evtValid = 1; evtWcol = pW; evtModf = pM; evtData = ~lastWr;
      end
      if (pendCnt > 0) pendCnt--;
      expRead = evtValid;
      if (engWrite) begin
        logic [7:0] exp;
        wrNum++;
        exp = retryExp ? lastWr : (curHasTx ? txData : 8'h00);
        check(engWrData == exp, retryExp ? "R7" : "R5", int'(engWrData), int'(exp));
        check(csN == 1'b0, "R3", int'(csN), 0);
        if (!retryExp) begin
          check(txReady == curHasTx, "R5", int'(txReady), int'(curHasTx));
          if (curHasTx) advTx = 1;
        end
        lastWr = engWrData;
        pW = (wrNum == wcolAt);
        pM = (wrNum == modfAt);
        retryExp = pW;
        pendCnt = 2;
      end
      if (rxValid) begin
        check(rxData == ~lastWr, "R11", int'(rxData), int'(~lastWr));
        rxCnt++;
        lastRxCyc = cyc;
      end
      if (engCfgWe) cfgCnt++;
      if (csN && !prevCsN) deas++;
      prevCsN = csN;
    end
  end

  task automatic setXfer(input vec_t v, input int xi);
    xferValid    = 1;
    xferLen      = 8'((xi == 0) ? v.len0 : v.len1);
    xferDelayUs  = 8'((xi == 0) ? v.dly0 : v.dly1);
    xferCsChange = (xi == 0) ? v.cs0[0] : 1'b0;
    xferHasTx    = (xi == 0) ? v.tx0[0] : v.tx1[0];
    xferLast     = (xi == v.nx - 1);
  endtask

  task automatic runMsg(input vec_t v, input int idx, output int gap);
    int xi, doneCyc;
    bit hs;
    wrNum = 0; rxCnt = 0; deas = 0; cfgCnt = 0;
    wcolAt = v.wcolAt; modfAt = v.modfAt;
    @(posedge clk); #1;
    msgValid = 1; msgCpol = idx[0]; msgCpha = idx[1]; msgLsbFirst = idx[2];
    msgDivider = 3'(idx + 1);
    @(negedge clk);
    check(msgReady && engCfgWe, "R2", int'(engCfgWe), 1);
    check({engCpol, engCpha, engLsbFirst, engDivider} == {idx[0], idx[1], idx[2], 3'(idx + 1)},
          "R2", int'(engDivider), idx + 1);
    @(posedge clk); #1;
    msgValid = 0;
    xi = 0;
    setXfer(v, 0);
    doneCyc = 0;
    forever begin
      @(negedge clk);
      if (msgDone) begin
        doneCyc = cyc;
        check(msgError == v.expErr[0], v.expErr != 0 ? "R8" : "R10", int'(msgError), v.expErr);
        check(int'(msgActualLen) == v.expLen, v.expErr != 0 ? "R8" : "R10",
              int'(msgActualLen), v.expLen);
        check(csN == 1'b1, "R3", int'(csN), 1);
        break;
      end
      hs = xferValid && xferReady;
      if (hs) curHasTx = (xi == 0) ? v.tx0[0] : v.tx1[0];
      @(posedge clk); #1;
      if (hs) begin
        xi++;
        if (xi < v.nx) setXfer(v, xi);
        else xferValid = 0;
      end
    end
    @(posedge clk); #1;
    xferValid = 0;
    @(negedge clk);
    check(rxCnt == v.expRx, "R11", rxCnt, v.expRx);
    check(deas == v.expDeas, "R4", deas, v.expDeas);
    check(cfgCnt == 1, "R2", cfgCnt, 1);
    gap = doneCyc - lastRxCyc;
  endtask

  initial begin
    int gap;
    vec_t dv;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    // R1 reset state
    check(csN == 1'b1, "R1", int'(csN), 1);
    check(msgDone == 1'b0 && msgError == 1'b0, "R1", int'(msgDone), 0);
    check(engWrite == 1'b0, "R1", int'(engWrite), 0);
    check(msgReady == 1'b1, "R1", int'(msgReady), 1);

    for (int i = 0; i < 8; i++) runMsg(VECS[i], i, gap);

    // R9 delay on the last transfer: 3 us * 4 ticks + 2
    dv = '{1, 1, 1, 3, 0, 0, 1, 0, 0, 0, 1, 0, 1, 1};
    runMsg(dv, 3, gap);
    check(gap == 3 * TICKS + 2, "R9", gap, 3 * TICKS + 2);
    // R9 zero delay
    dv = '{1, 2, 1, 0, 0, 0, 0, 0, 0, 0, 2, 0, 2, 1};
    runMsg(dv, 5, gap);
    check(gap == 2, "R9", gap, 2);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule